// File: doc/BRIEF.md
# Buffered SPI Master Engine

This block is an SPI master that runs transfers out of a shared 1024-byte buffer. The host writes the bytes to send into the buffer. It then writes one control word that holds a byte count, a go bit, a chip-select release bit and an interrupt enable. The engine sends that many bytes in mode 0, most significant bit first. Each byte that comes back on MISO is written over the buffer byte it was sent from, so when the run ends the buffer holds the reply. The block has no streaming data port. The host reaches the buffer and registers through a plain strobe bus with no back-pressure: a write is taken on the clock edge that samples the strobe, and read data appears one cycle after the read strobe.

Chip select is driven low when a run starts. When the run ends it goes high only if the release bit was set for that run. This lets one long transaction be split into fragments that each fit in the buffer. The SCK half period comes from a divider register. On completion a sticky pending flag is set, and the interrupt line follows that flag when the enable bit is set.

Top module: `spi_buf_master`

## Requirements
- R1: After reset, chip select is high, SCK and MOSI are low and irq is low. The control register reads 0x0000 and the divider register reads 0x0002.
- R2: Buffer bytes are at addresses 0x000–0x3FF and read back in data bits [7:0]. The control word is at 0x400: length in bits [9:0], pending in bit 12, enable in bit 13, release in bit 14, go/busy in bit 15. The divider is at 0x402. Read data is valid in the cycle after the read strobe.
- R3: The engine uses SPI mode 0. SCK idles low and stays low while chip select is high, and MOSI does not change while SCK is high. Bytes are sent in buffer order from address 0, most significant bit first.
- R4: The SCK half period is max(divider, 1) clocks. A run of N bytes completes N·(16·h+3) clock edges after the edge that took the go write. The pending flag and irq show the completion from that edge on.
- R5: A length field of 0 written with go transfers all 1024 bytes.
- R6: Each byte sampled from MISO replaces the buffer byte at the address it was sent from.
- R7: Chip select goes low on the edge that takes a go write. At completion it goes high only if the release bit was set for that run; otherwise it stays low.
- R8: An idle control write with bit 14 set and bit 15 clear drives chip select high.
- R9: Completion sets the pending flag, and irq equals pending AND enable. Writing 1 to bit 12 clears pending and writing 0 leaves it. Each idle control write loads the enable from bit 13.
- R10: While a run is busy, bit 15 reads 1, and host writes to the buffer, to the control word and to the divider are all ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 11 | Host byte address |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, one cycle after bus_rd |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Completion interrupt |

## Verification
Two situations are hard to reach from the ports. The first is host traffic that lands while a run is still shifting: buffer, control and divider writes that must leave no trace. The bench issues those writes a few cycles after a go write and reads back afterwards. The second is chip select held low across fragment boundaries. The bench chains fragments with the release bit clear and then releases chip select by force. Meanwhile a cycle-counting model of busy, pending and chip select is compared on every clock edge. A shift-register slave echoes the byte stream, so every reply byte shows whether the previous byte went out intact.

// File: rtl/spi_buf_pkg.sv
package spi_buf_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_LOAD, SQ_SHIFT} seq_t;
  typedef enum logic [1:0] {SH_IDLE, SH_LO, SH_HI} sh_t;
  localparam int CTL_PEND = 12;
  localparam int CTL_EN   = 13;
  localparam int CTL_REL  = 14;
  localparam int CTL_GO   = 15;
endpackage

// File: rtl/spi_buf_ram.sv
module spi_buf_ram #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re_a,
  input  logic [AW-1:0] raddr_a,
  output logic [7:0]    rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [7:0]    rdata_b
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re_a) rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/spi_buf_shifter.sv
module spi_buf_shifter
  import spi_buf_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [7:0]    tx_byte,
  input  logic [DW-1:0] half,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic [7:0]    rx_byte,
  output logic          byte_done
);
  sh_t           st;
  logic [DW-1:0] cnt;
  logic [DW-1:0] half_m1;
  logic [2:0]    bitc;
  logic [7:0]    sh;
  logic          samp;

  assign half_m1 = half - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SH_IDLE; cnt <= '0; bitc <= '0; sh <= '0;
      samp <= 1'b0; sck <= 1'b0; byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      case (st)
        SH_IDLE: if (load) begin
          sh <= tx_byte; cnt <= '0; bitc <= '0; st <= SH_LO;
        end
        SH_LO: if (cnt == half_m1) begin
          sck <= 1'b1; samp <= miso; cnt <= '0; st <= SH_HI;
        end else cnt <= cnt + 1'b1;
        SH_HI: if (cnt == half_m1) begin
          sck <= 1'b0; sh <= {sh[6:0], samp}; cnt <= '0;
          if (bitc == 3'd7) begin
            byte_done <= 1'b1; st <= SH_IDLE;
          end else begin
            bitc <= bitc + 3'd1; st <= SH_LO;
          end
        end else cnt <= cnt + 1'b1;
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign mosi    = (st == SH_IDLE) ? 1'b0 : sh[7];
  assign rx_byte = sh;
endmodule

// File: rtl/spi_buf_master.sv
module spi_buf_master
  import spi_buf_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int DIV_W     = 16,
  parameter int DIV_RESET = 2,
  localparam int LEN_W    = $clog2(BUF_BYTES),
  localparam int ADDR_W   = LEN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(BUF_BYTES);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(BUF_BYTES + 2);

  seq_t             seq;
  logic             busy;
  logic [LEN_W-1:0] len_q, idx_q;
  logic             last_q, en_q, pend_q, cs_n_q;
  logic [DIV_W-1:0] div_q, half;
  logic             is_buf, ctl_wr, div_wr, host_we, eng_we, last_byte;
  logic             ram_we;
  logic [LEN_W-1:0] ram_waddr;
  logic [7:0]       ram_wdata, ram_a, ram_b, rx_byte;
  logic             byte_done;
  logic [15:0]      ctl_view, rd_reg_q;
  logic             rd_buf_q;
  logic             unused_bits;

  assign unused_bits = ^bus_wdata[11:10];
  assign busy      = (seq != SQ_IDLE);
  assign is_buf    = ~bus_addr[ADDR_W-1];
  assign ctl_wr    = bus_wr && (bus_addr == A_CTL) && !busy;
  assign div_wr    = bus_wr && (bus_addr == A_DIV) && !busy;
  assign host_we   = bus_wr && is_buf && !busy;
  assign eng_we    = (seq == SQ_SHIFT) && byte_done;
  assign last_byte = (idx_q == len_q - 1'b1);
  assign half      = (div_q == '0) ? DIV_W'(1) : div_q;

  assign ram_we    = busy ? eng_we  : host_we;
  assign ram_waddr = busy ? idx_q   : bus_addr[LEN_W-1:0];
  assign ram_wdata = busy ? rx_byte : bus_wdata[7:0];

  spi_buf_ram #(.DEPTH(BUF_BYTES)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re_a(bus_rd), .raddr_a(bus_addr[LEN_W-1:0]), .rdata_a(ram_a),
    .raddr_b(idx_q), .rdata_b(ram_b)
  );

  spi_buf_shifter #(.DW(DIV_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(seq == SQ_LOAD), .tx_byte(ram_b),
    .half(half), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
    .rx_byte(rx_byte), .byte_done(byte_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq <= SQ_IDLE; idx_q <= '0; len_q <= '0; last_q <= 1'b0;
      en_q <= 1'b0; pend_q <= 1'b0; cs_n_q <= 1'b1;
      div_q <= DIV_W'(DIV_RESET);
    end else begin
      if (ctl_wr) begin
        if (bus_wdata[CTL_PEND]) pend_q <= 1'b0;
        en_q   <= bus_wdata[CTL_EN];
        last_q <= bus_wdata[CTL_REL];
        len_q  <= bus_wdata[LEN_W-1:0];
        if (bus_wdata[CTL_GO]) begin
          seq <= SQ_FETCH; idx_q <= '0; cs_n_q <= 1'b0;
        end else if (bus_wdata[CTL_REL]) begin
          cs_n_q <= 1'b1;
        end
      end
      if (div_wr) div_q <= bus_wdata[DIV_W-1:0];
      case (seq)
        SQ_FETCH: seq <= SQ_LOAD;
        SQ_LOAD:  seq <= SQ_SHIFT;
        SQ_SHIFT: if (byte_done) begin
          if (last_byte) begin
            seq <= SQ_IDLE; pend_q <= 1'b1;
            if (last_q) cs_n_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1; seq <= SQ_FETCH;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctl_view = '0;
    ctl_view[LEN_W-1:0] = len_q;
    ctl_view[CTL_PEND]  = pend_q;
    ctl_view[CTL_EN]    = en_q;
    ctl_view[CTL_REL]   = last_q;
    ctl_view[CTL_GO]    = busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_buf_q <= 1'b0; rd_reg_q <= '0;
    end else if (bus_rd) begin
      rd_buf_q <= is_buf;
      if (bus_addr == A_CTL)      rd_reg_q <= ctl_view;
      else if (bus_addr == A_DIV) rd_reg_q <= 16'(div_q);
      else                        rd_reg_q <= '0;
    end
  end

  assign bus_rdata = rd_buf_q ? {8'h00, ram_a} : rd_reg_q;
  assign spi_cs_n  = cs_n_q;
  assign irq       = pend_q & en_q;
endmodule

// File: rtl/spi_buf_checker.sv
module spi_buf_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sck,
  input logic             mosi,
  input logic             cs_n,
  input logic             busy,
  input logic             pend,
  input logic             last_q,
  input logic [DIV_W-1:0] div_q
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R3
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n) sck |-> $stable(mosi)); // R3
  AST_CS_DURING_RUN: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !cs_n); // R7
  AST_CS_KEEP_FRAG: assert property (@(posedge clk) disable iff (!rst_n) ($fell(busy) && !last_q) |-> !cs_n); // R7
  AST_DONE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> pend); // R9
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(div_q)); // R10
endmodule

bind spi_buf_master spi_buf_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n),
  .busy(busy), .pend(pend_q), .last_q(last_q), .div_q(div_q)
);

// File: tb/tb_spi_buf_master.sv
`timescale 1ns/1ps
module tb_spi_buf_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n, irq;

  always #2 clk = ~clk;

  spi_buf_master dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .irq(irq)
  );

  int errors = 0, checks = 0;
  bit finished = 0, clk_chk_on = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Shift-register slave: replies with the previous byte of the stream.
  logic [7:0] sl_sreg = 8'hA5;
  logic [7:0] mon_sh = 8'h00;
  int         mon_n = 0;
  logic [7:0] mon_q[$];
  assign spi_miso = sl_sreg[7];
  always @(posedge spi_sck) begin
    if (!spi_cs_n) begin
      sl_sreg <= {sl_sreg[6:0], spi_mosi};
      mon_sh = {mon_sh[6:0], spi_mosi};
      mon_n++;
      if (mon_n % 8 == 0) mon_q.push_back(mon_sh);
    end
  end

  // Cycle-counting reference model.
  bit m_busy, m_pend, m_en, m_last, m_cs_n;
  int m_rem, m_div;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_en = 0; m_last = 0; m_cs_n = 1;
      m_rem = 0; m_div = 2;
    end else if (m_busy) begin
      m_rem--;
      if (m_rem == 0) begin
        m_busy = 0; m_pend = 1;
        if (m_last) m_cs_n = 1;
      end
    end else if (bus_wr && bus_addr == 11'h400) begin
      if (bus_wdata[12]) m_pend = 0;
      m_en = bus_wdata[13];
      m_last = bus_wdata[14];
      if (bus_wdata[15]) begin
        automatic int n  = (bus_wdata[9:0] == 0) ? 1024 : int'(bus_wdata[9:0]);
        automatic int hp = (m_div == 0) ? 1 : m_div;
        m_rem = n * (16 * hp + 3);
        m_busy = 1; m_cs_n = 0;
      end else if (bus_wdata[14]) m_cs_n = 1;
    end else if (bus_wr && bus_addr == 11'h402) begin
      m_div = int'(bus_wdata);
    end
  end

  always @(negedge clk) begin
    if (rst_n && clk_chk_on) begin
      chk(spi_cs_n == m_cs_n, "R7", "cs_n vs model", int'(spi_cs_n), int'(m_cs_n));
      chk(irq == (m_pend && m_en), "R9", "irq vs model", int'(irq), int'(m_pend && m_en));
      chk(!(spi_cs_n && spi_sck), "R3", "sck while deselected", int'(spi_sck), 0);
    end
  end

  task automatic wr(input logic [10:0] a, input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; d = bus_rdata;
  endtask

  function automatic logic [15:0] ctlw(int n, bit go, bit rel, bit en, bit w1c);
    return {go, rel, en, w1c, 2'b00, 10'(n)};
  endfunction

  logic [7:0] tx [1024];
  logic [7:0] prev_tx = 8'hA5;

  task automatic fill(int n, int seed);
    for (int i = 0; i < n; i++) begin
      tx[i] = 8'((seed + i * 37) & 255);
      wr(11'(i), {8'h00, tx[i]});
    end
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy) @(negedge clk);
  endtask

  task automatic check_run(int n, string req);
    logic [15:0] d;
    int bad_rx = 0, bad_tx = 0;
    chk(mon_q.size() == n, req, "bytes shifted", mon_q.size(), n);
    for (int i = 0; i < n; i++) begin
      automatic logic [7:0] exp_rx = (i == 0) ? prev_tx : tx[i-1];
      automatic logic [7:0] got;
      rd(11'(i), d);
      if (d != {8'h00, exp_rx}) begin
        bad_rx++;
        if (bad_rx < 4) chk(0, "R6", "buffer reply byte", int'(d), int'(exp_rx));
      end
      got = (mon_q.size() > 0) ? mon_q.pop_front() : 8'hxx;
      if (got !== tx[i]) begin
        bad_tx++;
        if (bad_tx < 4) chk(0, "R3", "MOSI byte", int'(got), int'(tx[i]));
      end
    end
    chk(bad_rx == 0, "R6", "in-place reply bytes mismatched", bad_rx, 0);
    chk(bad_tx == 0, "R3", "MOSI bytes mismatched", bad_tx, 0);
    prev_tx = tx[n-1];
    mon_q.delete();
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0x1 expected=0x0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int cyc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(spi_cs_n == 1 && spi_sck == 0 && spi_mosi == 0 && irq == 0, "R1",
        "pins after reset", {spi_cs_n, spi_sck, spi_mosi, irq}, 4'b1000);
    rd(11'h400, d); chk(d == 16'h0000, "R1", "control after reset", d, 0);
    rd(11'h402, d); chk(d == 16'h0002, "R2", "divider after reset", d, 2);
    clk_chk_on = 1;

    // Single message, 4 bytes, with writes attempted mid-run.
    wr(11'd200, 16'h003C);
    fill(4, 8'h11);
    wr(11'h400, ctlw(4, 1, 1, 1, 0));
    rd(11'h400, d); chk(d == 16'hE004, "R10", "control read while busy (R2 layout)", d, 16'hE004);
    wr(11'd200, 16'h0077);
    wr(11'h400, 16'h1000);
    wr(11'h402, 16'h0007);
    wait_idle();
    chk(irq == 1, "R9", "irq after run", irq, 1);
    chk(spi_cs_n == 1, "R7", "cs released after last run", spi_cs_n, 1);
    rd(11'h400, d); chk(d == 16'h7004, "R2", "control after run", d, 16'h7004);
    rd(11'd200, d); chk(d == 16'h003C, "R10", "buffer write during run", d, 16'h003C);
    rd(11'h402, d); chk(d == 16'h0002, "R10", "divider write during run", d, 2);
    check_run(4, "R3");

    // Clear pending by writing 1, enable kept.
    wr(11'h400, ctlw(0, 0, 0, 1, 1));
    @(negedge clk);
    chk(irq == 0, "R9", "irq after W1C", irq, 0);
    rd(11'h400, d); chk(d == 16'h2000, "R9", "control after W1C", d, 16'h2000);

    // Fragmented transaction: chip select held between fragments.
    fill(3, 8'h40);
    wr(11'h400, ctlw(3, 1, 0, 1, 0));
    wait_idle();
    chk(spi_cs_n == 0, "R7", "cs held after fragment", spi_cs_n, 0);
    check_run(3, "R3");
    wr(11'h400, ctlw(0, 0, 0, 1, 1));
    chk(spi_cs_n == 0, "R7", "cs held across idle control write", spi_cs_n, 0);
    fill(2, 8'h81);
    wr(11'h400, ctlw(2, 1, 0, 1, 0));
    wait_idle();
    chk(spi_cs_n == 0, "R7", "cs held after second fragment", spi_cs_n, 0);
    check_run(2, "R6");
    wr(11'h400, 16'h4000);
    chk(spi_cs_n == 1, "R8", "forced release", spi_cs_n, 1);
    wr(11'h400, 16'h0000);

    // Last fragment with interrupt disabled.
    fill(2, 8'hC3);
    wr(11'h400, ctlw(2, 1, 1, 0, 0));
    wait_idle();
    chk(irq == 0, "R9", "irq masked by enable", irq, 0);
    rd(11'h400, d); chk(d[12] == 1'b1, "R9", "pending set with enable low", d[12], 1);
    check_run(2, "R6");
    wr(11'h400, 16'h0000);
    rd(11'h400, d); chk(d[12] == 1'b1, "R9", "writing 0 keeps pending", d[12], 1);
    wr(11'h400, 16'h1000);
    rd(11'h400, d); chk(d[12] == 1'b0, "R9", "writing 1 clears pending", d[12], 0);

    // Divider 0 behaves as 1; divider 5 timing measured.
    wr(11'h402, 16'h0000);
    fill(1, 8'h5A);
    wr(11'h400, ctlw(1, 1, 1, 1, 0));
    cyc = 0;
    while (!irq && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(cyc == 19, "R4", "cycles with divider 0", cyc, 19);
    check_run(1, "R4");
    wr(11'h400, ctlw(0, 0, 0, 1, 1));
    wr(11'h402, 16'h0005);
    fill(2, 8'h97);
    wr(11'h400, ctlw(2, 1, 1, 1, 0));
    cyc = 0;
    while (!irq && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(cyc == 166, "R4", "cycles with divider 5", cyc, 166);
    check_run(2, "R4");
    wr(11'h400, ctlw(0, 0, 0, 1, 1));

    // Length 0 means the full buffer.
    wr(11'h402, 16'h0001);
    fill(1024, 8'h03);
    wr(11'h400, ctlw(0, 1, 1, 1, 0));
    wait_idle();
    chk(irq == 1, "R5", "full-buffer run completes", irq, 1);
    check_run(1024, "R5");

    finished = 1;
    clk_chk_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule